// File: doc/BRIEF.md
# MII Port Switchover Sequencer

This block moves a MAC's MII datapath and its MII clocks from one physical port to the other: the on-chip PHY (port 0) or the external MII port (port 1). A one-cycle switch request, qualified with a target port number, starts a fixed handshake. Transmit and receive are switched off and the sequencer waits for the receiver to report that it has halted. It then parks the MII clock select on an "all clocks off" code and lets the old clocks drain. Next it steers the whole MII signal group to the target port and selects that port's clocks. It waits again for the new clocks to settle, then turns the transmitter back on and, one cycle later, the receiver.

Both settling waits are counted in system-clock cycles. They are derived from two programmable clock-period inputs given in nanoseconds and from two flags that say which port clocks are running. If the receiver never confirms the halt, a timeout gives up the attempt, flags an error and leaves the port where it was. The clock select is intended to drive an external clock mux, and the data select a datapath mux for RXD[3:0], RX_DV, RX_ER, TXD[3:0], TX_EN, CRS and COL.

Top module: `mii_port_switcher`

## Requirements
- R1: After reset, data_sel is 0, clk_sel is 2'b00, tx_en and rx_en are 1, and busy and timeout_err are 0.
- R2: A request accepted while idle drops tx_en and rx_en and raises busy in the next cycle. clk_sel stays unchanged until rx_halted is seen high.
- R3: The cycle after rx_halted is seen, clk_sel takes the park code 2'b10. It holds that code for exactly ceil(5*Tslow/SYS_CLK_NS)+2 cycles. Tslow is the largest period among the ports whose running flag is set, or 0 if no port clock runs. tx_en and rx_en stay 0 while parked.
- R4: data_sel changes to the target port while clk_sel is still parked. clk_sel then takes the target's code (2'b00 for port 0, 2'b01 for port 1), and it never shows a port code that differs from data_sel.
- R5: After clk_sel takes the target code, tx_en stays 0 for exactly ceil(5*Tnew/SYS_CLK_NS)+1 cycles, where Tnew is the target port's period, and then rises.
- R6: rx_en rises one cycle after tx_en, and busy falls in that same cycle.
- R7: A switch request that arrives while busy is ignored, and the sequence in progress ends on its own target.
- R8: If rx_halted stays low for HALT_TIMEOUT+1 cycles in the halt wait, timeout_err rises, tx_en and rx_en return to 1, busy falls, and data_sel and clk_sel keep their previous values. The total busy time is HALT_TIMEOUT+1 cycles.
- R9: timeout_err holds until the next accepted request, which clears it.
- R10: The sequence is the same in both directions. A request for the port already selected still runs the full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| switch_req | input | 1 | One-cycle request to change port |
| target_port | input | 1 | Port to move to (0 internal PHY, 1 external MII) |
| int_clk_period | input | PER_W | Internal PHY MII clock period, ns |
| ext_clk_period | input | PER_W | External MII clock period, ns |
| int_clk_running | input | 1 | Internal PHY clock is running |
| ext_clk_running | input | 1 | External MII clock is running |
| rx_halted | input | 1 | Receiver reports it has fully stopped |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| data_sel | output | 1 | MII signal-group steering select |
| clk_sel | output | 2 | MII clock select: 00 internal, 01 external, 10 all off |
| busy | output | 1 | Switch sequence in progress |
| timeout_err | output | 1 | Last attempt timed out waiting for receiver halt |

## Verification
The bench builds the block with SYS_CLK_NS at 10 to match its clock, so periods of 25, 33 and 40 ns give waits with and without a rounding remainder. It sets HALT_TIMEOUT to 50, which makes the halt-timeout path and its exact busy length reachable within a short run. With these values the bench can count every cycle of both waits. It covers the cases where only the old port's clock, only the new port's clock, or no clock runs, and it compares the cycle counts with the ceiling formula.

// File: rtl/mii_sw_pkg.sv
package mii_sw_pkg;
  localparam logic [1:0] CLK_CODE_INT  = 2'b00;
  localparam logic [1:0] CLK_CODE_EXT  = 2'b01;
  localparam logic [1:0] CLK_CODE_PARK = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_HALT   = 3'd1,
    ST_PARK   = 3'd2,
    ST_STEER  = 3'd3,
    ST_SETTLE = 3'd4,
    ST_RX_ON  = 3'd5
  } sw_state_e;

  function automatic logic [1:0] port_code(input logic port);
    return port ? CLK_CODE_EXT : CLK_CODE_INT;
  endfunction
endpackage

// File: rtl/mii_sw_wait_calc.sv
module mii_sw_wait_calc #(
  parameter int PER_W      = 10,
  parameter int SYS_CLK_NS = 10,
  parameter int CNT_W      = 16
) (
  input  logic [PER_W-1:0] int_period,
  input  logic [PER_W-1:0] ext_period,
  input  logic             int_running,
  input  logic             ext_running,
  input  logic             target,
  output logic [CNT_W-1:0] park_cycles,
  output logic [CNT_W-1:0] settle_cycles
);
  localparam int NPORT = 2;

  logic [PER_W-1:0] period [NPORT];
  logic             running [NPORT];
  logic [CNT_W-1:0] cyc [NPORT];
  logic [CNT_W-1:0] run_cyc [NPORT];

  assign period[0]  = int_period;
  assign period[1]  = ext_period;
  assign running[0] = int_running;
  assign running[1] = ext_running;

  // Each port's wait: five periods in ns, rounded up to whole system cycles.
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [CNT_W-1:0] five_per;
    assign five_per   = CNT_W'(period[p]) * CNT_W'(5);
    assign cyc[p]     = (five_per + CNT_W'(SYS_CLK_NS - 1)) / CNT_W'(SYS_CLK_NS);
    assign run_cyc[p] = running[p] ? cyc[p] : '0;
  end

  // Drain wait covers the slowest clock that was running.
  assign park_cycles   = (run_cyc[0] > run_cyc[1]) ? run_cyc[0] : run_cyc[1];
  // Settle wait covers the clock of the port being brought up.
  assign settle_cycles = cyc[target];
endmodule

// File: rtl/mii_sw_timer.sv
module mii_sw_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load | dec;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                cnt_d = load_val;
    else if (dec && cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/mii_sw_ctrl.sv
module mii_sw_ctrl
  import mii_sw_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int HALT_TIMEOUT = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             switch_req,
  input  logic             target_port,
  input  logic             rx_halted,
  input  logic             tmr_zero,
  input  logic [CNT_W-1:0] park_cycles,
  input  logic [CNT_W-1:0] settle_cycles,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             tmr_dec,
  output logic             tgt_q,
  output logic             data_sel,
  output logic [1:0]       clk_sel,
  output logic             tx_en,
  output logic             rx_en,
  output logic             busy,
  output logic             timeout_err
);
  sw_state_e  state_q, state_d;
  logic       tgt_d, data_sel_d, tx_en_d, rx_en_d, err_d;
  logic [1:0] clk_sel_d;

  always_comb begin
    state_d    = state_q;
    tgt_d      = tgt_q;
    data_sel_d = data_sel;
    clk_sel_d  = clk_sel;
    tx_en_d    = tx_en;
    rx_en_d    = rx_en;
    err_d      = timeout_err;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    tmr_dec    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (switch_req) begin
          tgt_d    = target_port;
          tx_en_d  = 1'b0;
          rx_en_d  = 1'b0;
          err_d    = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(HALT_TIMEOUT);
          state_d  = ST_HALT;
        end
      end
      ST_HALT: begin
        if (rx_halted) begin
          clk_sel_d = CLK_CODE_PARK;
          tmr_load  = 1'b1;
          tmr_val   = park_cycles;
          state_d   = ST_PARK;
        end else if (tmr_zero) begin
          err_d   = 1'b1;
          tx_en_d = 1'b1;
          rx_en_d = 1'b1;
          state_d = ST_IDLE;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      ST_PARK: begin
        if (tmr_zero) begin
          data_sel_d = tgt_q;
          state_d    = ST_STEER;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      ST_STEER: begin
        clk_sel_d = port_code(data_sel);
        tmr_load  = 1'b1;
        tmr_val   = settle_cycles;
        state_d   = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (tmr_zero) begin
          tx_en_d = 1'b1;
          state_d = ST_RX_ON;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      ST_RX_ON: begin
        rx_en_d = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      tgt_q       <= 1'b0;
      data_sel    <= 1'b0;
      clk_sel     <= CLK_CODE_INT;
      tx_en       <= 1'b1;
      rx_en       <= 1'b1;
      timeout_err <= 1'b0;
    end else begin
      state_q     <= state_d;
      tgt_q       <= tgt_d;
      data_sel    <= data_sel_d;
      clk_sel     <= clk_sel_d;
      tx_en       <= tx_en_d;
      rx_en       <= rx_en_d;
      timeout_err <= err_d;
    end
  end

  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/mii_port_switcher.sv
module mii_port_switcher #(
  parameter int PER_W        = 10,
  parameter int SYS_CLK_NS   = 10,
  parameter int HALT_TIMEOUT = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             switch_req,
  input  logic             target_port,
  input  logic [PER_W-1:0] int_clk_period,
  input  logic [PER_W-1:0] ext_clk_period,
  input  logic             int_clk_running,
  input  logic             ext_clk_running,
  input  logic             rx_halted,
  output logic             tx_en,
  output logic             rx_en,
  output logic             data_sel,
  output logic [1:0]       clk_sel,
  output logic             busy,
  output logic             timeout_err
);
  localparam int TO_W  = $clog2(HALT_TIMEOUT + 1);
  localparam int WT_W  = PER_W + 3;
  localparam int CNT_W = (TO_W > WT_W) ? TO_W : WT_W;

  logic             tmr_load, tmr_dec, tmr_zero, tgt_q;
  logic [CNT_W-1:0] tmr_val, park_cycles, settle_cycles;

  mii_sw_wait_calc #(
    .PER_W(PER_W), .SYS_CLK_NS(SYS_CLK_NS), .CNT_W(CNT_W)
  ) u_calc (
    .int_period   (int_clk_period),
    .ext_period   (ext_clk_period),
    .int_running  (int_clk_running),
    .ext_running  (ext_clk_running),
    .target       (tgt_q),
    .park_cycles  (park_cycles),
    .settle_cycles(settle_cycles)
  );

  mii_sw_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .dec     (tmr_dec),
    .zero    (tmr_zero)
  );

  mii_sw_ctrl #(.CNT_W(CNT_W), .HALT_TIMEOUT(HALT_TIMEOUT)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .switch_req   (switch_req),
    .target_port  (target_port),
    .rx_halted    (rx_halted),
    .tmr_zero     (tmr_zero),
    .park_cycles  (park_cycles),
    .settle_cycles(settle_cycles),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .tmr_dec      (tmr_dec),
    .tgt_q        (tgt_q),
    .data_sel     (data_sel),
    .clk_sel      (clk_sel),
    .tx_en        (tx_en),
    .rx_en        (rx_en),
    .busy         (busy),
    .timeout_err  (timeout_err)
  );
endmodule

// File: rtl/mii_sw_chk.sv
module mii_sw_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       tx_en,
  input logic       rx_en,
  input logic       data_sel,
  input logic [1:0] clk_sel,
  input logic       timeout_err
);
  // R4
  clksel_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel != 2'b10) |-> (clk_sel == {1'b0, data_sel}));

  // R3
  park_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'b10) |-> (!tx_en && !rx_en));

  // R2
  halt_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!tx_en && !rx_en));

  // R6
  rx_after_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_en) && !timeout_err) |-> $past(tx_en));

  // R6
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (tx_en && rx_en));

  // R8
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> (!busy && tx_en && rx_en && $stable(clk_sel) && $stable(data_sel)));
endmodule

bind mii_port_switcher mii_sw_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .tx_en      (tx_en),
  .rx_en      (rx_en),
  .data_sel   (data_sel),
  .clk_sel    (clk_sel),
  .timeout_err(timeout_err)
);

// File: tb/tb_mii_port_switcher.sv
module tb_mii_port_switcher;
  localparam int PER_W = 10;
  localparam int SYS_NS = 10;
  localparam int TO = 50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic switch_req = 1'b0, target_port = 1'b0;
  logic [PER_W-1:0] int_per = '0, ext_per = '0;
  logic int_run = 1'b0, ext_run = 1'b0, rx_halted = 1'b0;
  logic tx_en, rx_en, data_sel, busy, timeout_err;
  logic [1:0] clk_sel;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  mii_port_switcher #(.PER_W(PER_W), .SYS_CLK_NS(SYS_NS), .HALT_TIMEOUT(TO)) dut (
    .clk(clk), .rst_n(rst_n), .switch_req(switch_req), .target_port(target_port),
    .int_clk_period(int_per), .ext_clk_period(ext_per),
    .int_clk_running(int_run), .ext_clk_running(ext_run), .rx_halted(rx_halted),
    .tx_en(tx_en), .rx_en(rx_en), .data_sel(data_sel), .clk_sel(clk_sel),
    .busy(busy), .timeout_err(timeout_err));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {target, int_run, ext_run, int_per, ext_per, park_len, settle_len}
  localparam int NV = 5;
  localparam logic [38:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b1, 10'd40, 10'd25, 8'd22, 8'd14},
    {1'b0, 1'b1, 1'b1, 10'd40, 10'd25, 8'd22, 8'd21},
    {1'b1, 1'b1, 1'b0, 10'd33, 10'd25, 8'd19, 8'd14},
    {1'b0, 1'b0, 1'b1, 10'd33, 10'd25, 8'd15, 8'd18},
    {1'b0, 1'b0, 1'b0, 10'd40, 10'd25, 8'd2,  8'd21}
  };

  task automatic pulse_req(input logic tgt);
    @(negedge clk);
    switch_req = 1'b1; target_port = tgt;
    @(negedge clk);
    switch_req = 1'b0;
  endtask

  task automatic run_switch(input logic tgt, input int park_exp, input int settle_exp,
                            input bool_dummy_unused);
    int park_n, settle_n;
    logic [1:0] code;
    code = {1'b0, tgt};
    pulse_req(tgt);
    // R2: tx/rx off, busy up, clocks untouched before halt confirmed
    chk("R2 tx_en off", int'(tx_en), 0);
    chk("R2 rx_en off", int'(rx_en), 0);
    chk("R2 busy", int'(busy), 1);
    chk("R9 err cleared", int'(timeout_err), 0);
    repeat (3) @(negedge clk);
    chk("R2 clk_sel held", int'(clk_sel == 2'b10), 0);
    rx_halted = 1'b1;
    @(negedge clk);
    park_n = 0;
    while (clk_sel == 2'b10) begin
      park_n++;
      @(negedge clk);
      if (park_n > 300) break;
    end
    chk("R3 park length", park_n, park_exp);
    chk("R4 data_sel target", int'(data_sel), int'(tgt));
    chk("R4 clk_sel target code", int'(clk_sel), int'(code));
    settle_n = 0;
    while (!tx_en) begin
      settle_n++;
      @(negedge clk);
      if (settle_n > 300) break;
    end
    chk("R5 settle length", settle_n, settle_exp);
    chk("R6 rx_en lags tx_en", int'(rx_en), 0);
    rx_halted = 1'b0;
    @(negedge clk);
    chk("R6 rx_en up", int'(rx_en), 1);
    chk("R6 busy down", int'(busy), 0);
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 data_sel", int'(data_sel), 0);
    chk("R1 clk_sel", int'(clk_sel), 0);
    chk("R1 tx_en", int'(tx_en), 1);
    chk("R1 rx_en", int'(rx_en), 1);
    chk("R1 busy", int'(busy), 0);
    chk("R1 timeout_err", int'(timeout_err), 0);

    // R3 R5 R10: both directions, old-only/new-only/no clocks, same-port switch
    for (int i = 0; i < NV; i++) begin
      {target_port, int_run, ext_run, int_per, ext_per} = VEC[i][38:16];
      run_switch(VEC[i][38], int'(VEC[i][15:8]), int'(VEC[i][7:0]), 1'b0);
    end

    // R8: receiver never halts (port is 0 now)
    int_run = 1'b1; ext_run = 1'b1; int_per = 10'd40; ext_per = 10'd25;
    begin
      int busy_n;
      pulse_req(1'b1);
      busy_n = 1;
      while (busy) begin
        @(negedge clk);
        if (busy) busy_n++;
        if (busy_n > 500) break;
      end
      chk("R8 busy length", busy_n, TO + 1);
      chk("R8 timeout_err", int'(timeout_err), 1);
      chk("R8 tx_en restored", int'(tx_en), 1);
      chk("R8 rx_en restored", int'(rx_en), 1);
      chk("R8 data_sel kept", int'(data_sel), 0);
      chk("R8 clk_sel kept", int'(clk_sel), 0);
      repeat (4) @(negedge clk);
      chk("R9 err holds", int'(timeout_err), 1);
    end

    // R7: request for port 0 during a switch to port 1 is ignored
    pulse_req(1'b1);
    chk("R9 err cleared by request", int'(timeout_err), 0);
    repeat (2) @(negedge clk);
    switch_req = 1'b1; target_port = 1'b0;
    @(negedge clk);
    switch_req = 1'b0;
    rx_halted = 1'b1;
    repeat (5) @(negedge clk);
    switch_req = 1'b1; target_port = 1'b0;
    @(negedge clk);
    switch_req = 1'b0;
    while (!rx_en) @(negedge clk);
    rx_halted = 1'b0;
    chk("R7 data_sel keeps first target", int'(data_sel), 1);
    chk("R7 clk_sel keeps first target", int'(clk_sel), 1);
    repeat (3) @(negedge clk);
    chk("R7 no restart", int'(busy), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule